// File: doc/BRIEF.md
# Quad I/O execute-in-place read frontend for serial flash

This block is the device side of a serial flash read path. It watches chip select, the serial clock and four data lines, all oversampled by a faster system clock. It decodes a configuration write that can arm execute-in-place operation, and it serves quad I/O fast reads. Each read carries a 24-bit address four bits per clock, then a fixed run of dummy clocks, then streams bytes back as nibbles from a synchronous memory read port that the block drives.

While execute-in-place is active, a transaction carries no opcode and starts directly with the address. A confirmation bit on DQ0 in the first dummy clock of every read decides whether the next transaction starts with an opcode or with an address. Serial clock modes 0 and 3 are both accepted.

Top module: `xip_flash_frontend`

## Requirements
- R1: After reset the data line enables are low, no memory read is issued, execute-in-place is off (the first transaction is decoded as an opcode) and the configuration enable bit reads 1 (disabled).
- R2: Opcode EBh, sent MSB first on DQ0 sampled on rising edges, starts a quad read: 6 clocks carry the address on DQ[3:0] high nibble first, then DUMMY_CYC dummy clocks, then data is driven on the falling edges, high nibble first, with all four enables set together.
- R3: The read address advances by one after every byte and wraps from FFFFFFh to 000000h.
- R4: Opcode 81h followed by 8 bits on DQ0 (MSB first) writes the configuration register; bit 3 of that byte is the active-low execute-in-place enable.
- R5: With the enable bit at 0, a read whose DQ0 is 0 in the first dummy clock makes the next transaction start with the address and carry no opcode.
- R6: A confirmation bit of 1 leaves execute-in-place, so the next transaction starts with an 8-bit opcode.
- R7: DQ3 to DQ1 in the first dummy clock have no effect on the mode decision.
- R8: With the enable bit at 1, a confirmation bit of 0 does not enter execute-in-place.
- R9: Chip select high ends any transaction within a few system clocks, drops all enables, and the next transaction restarts at its first item.
- R10: An opcode other than EBh or 81h leaves the data lines undriven for the rest of the transaction and changes no state.
- R11: Serial clock modes 0 (idle low) and 3 (idle high) give the same results.
- R12: The memory port issues one single-cycle read per byte plus one prefetch, starting at the received address; read data is taken one clock after mem_en_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low chip select |
| dq_i | input | 4 | Data lines as seen at the pads |
| dq_o | output | 4 | Data driven onto the lines |
| dq_oe_o | output | 4 | Output enables for the data lines |
| mem_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_data_i | input | 8 | Memory read data, valid the clock after mem_en_o |

## Verification
The assertions watch, on every clock, that the output nibble only moves after a serial clock falling edge, that the enables are all-on or all-off and drop once chip select has been high, that memory strobes are single pulses, and that every fetch after the first of a read steps the address by one. Only the bench scenarios can show the mode decisions: whether a transaction after a confirmation bit is taken as address-first or opcode-first, the effect of the configuration write, the ignored upper lines in the first dummy clock and the behaviour under both clock modes, each visible only as correct or corrupted read data.

// File: rtl/xip_pkg.sv
package xip_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_VCR, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP
  } xip_st_e;

  localparam logic [7:0] OP_QREAD  = 8'hEB;
  localparam logic [7:0] OP_CFG_WR = 8'h81;
  localparam int unsigned CFG_XIP_BIT = 3;
endpackage

// File: rtl/xip_sync.sv
module xip_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xip_ctrl.sv
module xip_ctrl
  import xip_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DUMMY_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,     // synchronized, high = deselected
  input  logic              rise_i,
  input  logic [3:0]        dq_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              data_ph_o
);
  localparam int unsigned ADDR_CLKS = ADDR_W / 4;
  localparam int unsigned MAXC = (DUMMY_CYC > 8) ? DUMMY_CYC : 8;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CYC - 1);

  xip_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              xip_dis_q;  // active-low enable bit of the config register
  logic              xip_q;
  logic              load_q;
  logic [7:0]        byte_in;

  assign byte_in = {sh_q, dq_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CMD;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      xip_dis_q <= 1'b1;
      xip_q     <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (cs_i) begin
        st_q  <= xip_q ? ST_ADDR : ST_CMD;
        cnt_q <= '0;
      end else if (rise_i) begin
        unique case (st_q)
          ST_CMD, ST_VCR: begin
            sh_q  <= byte_in[6:0];
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == BYTE_LAST) begin
              cnt_q <= '0;
              if (st_q == ST_VCR) begin
                xip_dis_q <= byte_in[CFG_XIP_BIT];
                st_q      <= ST_SKIP;
              end else if (byte_in == OP_QREAD) st_q <= ST_ADDR;
              else if (byte_in == OP_CFG_WR)    st_q <= ST_VCR;
              else                              st_q <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            addr_q <= {addr_q[ADDR_W-5:0], dq_i};
            cnt_q  <= cnt_q + CNT_W'(1);
            if (cnt_q == ADDR_LAST) begin
              cnt_q  <= '0;
              load_q <= 1'b1;
              st_q   <= ST_DUMMY;
            end
          end
          ST_DUMMY: begin
            // confirmation bit on DQ0 only; upper lines are don't-care
            if (cnt_q == '0) xip_q <= ~xip_dis_q & ~dq_i[0];
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == DUMMY_LAST) begin
              cnt_q <= '0;
              st_q  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign load_o    = load_q;
  assign addr_o    = addr_q;
  assign data_ph_o = (st_q == ST_DATA);
endmodule

// File: rtl/xip_dpath.sv
module xip_dpath #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              fall_i,
  input  logic              data_ph_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        mem_data_i,
  output logic [3:0]        dq_o,
  output logic              oe_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] ptr_q, mem_addr_q, ptr_nx;
  logic [7:0]        byte_q;
  logic [3:0]        low_q, dq_q;
  logic              hi_q, oe_q, mem_en_q, rd_pend_q;

  assign ptr_nx = ptr_q + ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      mem_addr_q <= '0;
      byte_q     <= '0;
      low_q      <= '0;
      dq_q       <= '0;
      hi_q       <= 1'b1;
      oe_q       <= 1'b0;
      mem_en_q   <= 1'b0;
      rd_pend_q  <= 1'b0;
    end else begin
      mem_en_q  <= 1'b0;
      rd_pend_q <= mem_en_q;
      if (rd_pend_q) byte_q <= mem_data_i;
      if (load_i) begin
        ptr_q      <= addr_i;
        mem_addr_q <= addr_i;
        mem_en_q   <= 1'b1;
      end
      if (cs_i) begin
        oe_q <= 1'b0;
        hi_q <= 1'b1;
      end else if (fall_i && data_ph_i) begin
        oe_q <= 1'b1;
        if (hi_q) begin
          // emit high nibble, park low nibble, prefetch next byte
          dq_q       <= byte_q[7:4];
          low_q      <= byte_q[3:0];
          ptr_q      <= ptr_nx;
          mem_addr_q <= ptr_nx;
          mem_en_q   <= 1'b1;
          hi_q       <= 1'b0;
        end else begin
          dq_q <= low_q;
          hi_q <= 1'b1;
        end
      end
    end
  end

  assign dq_o       = dq_q;
  assign oe_o       = oe_q;
  assign mem_en_o   = mem_en_q;
  assign mem_addr_o = mem_addr_q;
endmodule

// File: rtl/xip_flash_frontend.sv
module xip_flash_frontend #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DUMMY_CYC = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  logic [5:0]        pins_s;
  logic              cs_s, sclk_s, sclk_q, sclk_rise, sclk_fall;
  logic [3:0]        dq_s;
  logic              addr_load, data_ph, oe;
  logic [ADDR_W-1:0] addr_rx;

  xip_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b10_0000)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sclk_i, dq_i}),
    .q_o (pins_s)
  );
  assign {cs_s, sclk_s, dq_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  xip_ctrl #(.ADDR_W(ADDR_W), .DUMMY_CYC(DUMMY_CYC)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_i      (cs_s),
    .rise_i    (sclk_rise),
    .dq_i      (dq_s),
    .load_o    (addr_load),
    .addr_o    (addr_rx),
    .data_ph_o (data_ph)
  );

  xip_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk_i, .rst_ni,
    .cs_i       (cs_s),
    .fall_i     (sclk_fall),
    .data_ph_i  (data_ph),
    .load_i     (addr_load),
    .addr_i     (addr_rx),
    .mem_data_i,
    .dq_o,
    .oe_o       (oe),
    .mem_en_o,
    .mem_addr_o
  );

  assign dq_oe_o = {4{oe}};
endmodule

// File: rtl/xip_flash_frontend_chk.sv
module xip_flash_frontend_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [3:0]        dq_o,
  input logic [3:0]        dq_oe_o,
  input logic              mem_en_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              fall_i,
  input logic              load_i
);
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       prev_addr_q <= '0;
    else if (mem_en_o) prev_addr_q <= mem_addr_o;

  // R2: output nibble only moves after a serial clock falling edge
  p_dq_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dq_o) |-> $past(fall_i));

  // R2: all four lines turn around together
  p_oe_uniform_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o == 4'h0) || (dq_oe_o == 4'hF));

  // R9: chip select held high releases the lines
  p_oe_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |=> (dq_oe_o == 4'h0));

  // R12: single-cycle read strobes
  p_mem_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !mem_en_o);

  // R3: every fetch after the first of a read steps the address by one
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !$past(load_i)) |-> (mem_addr_o == prev_addr_q + ADDR_W'(1)));
endmodule

bind xip_flash_frontend xip_flash_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .dq_o, .dq_oe_o, .mem_en_o, .mem_addr_o,
  .fall_i (sclk_fall),
  .load_i (addr_load)
);

// File: tb/xip_flash_frontend_bench.sv
`timescale 1ns/1ps
module xip_flash_frontend_bench;
  localparam int H = 8;       // serial half period in system clocks
  localparam int DUMMY = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  dq_in = 4'h0;
  logic [3:0]  dq_out, dq_oe;
  logic        mem_en;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data = 8'h00;

  always #10 clk = ~clk;

  xip_flash_frontend u_xip_flash_frontend (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .mem_en_o(mem_en),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data)
  );

  function automatic logic [7:0] memf(input logic [23:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_en) mem_data <= memf(mem_addr);

  int n_chk = 0, n_err = 0;
  int fetch_cnt = 0;
  logic [23:0] first_addr = '0;
  bit done = 0;

  // reference model state
  bit         m_xip = 0;
  logic [7:0] m_cfg = 8'hFF;

  always @(negedge clk) if (mem_en) begin
    fetch_cnt++;
    if (fetch_cnt == 1) first_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] oe);
    sclk = 1'b0;
    dq_in = din;
    wclk(H);
    dout = dq_out;
    oe = dq_oe;
    sclk = 1'b1;
    wclk(H);
  endtask

  task automatic start(input bit mode3);
    sclk = mode3;
    wclk(H);
    cs_n = 1'b0;
    wclk(H);
  endtask

  task automatic stop(input bit mode3);
    if (!mode3) begin
      sclk = 1'b0;
      wclk(H);
    end
    cs_n = 1'b1;
    wclk(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [3:0] d, o;
    for (int i = 7; i >= 0; i--) cyc({3'b000, b[i]}, d, o);
  endtask

  task automatic qread(input bit mode3, input logic [23:0] addr, input bit xb,
                       input logic [2:0] junk, input int nbytes, input string tag);
    logic [3:0] d, o, hi, lo, ohi, olo;
    logic [23:0] a;
    fetch_cnt = 0;
    start(mode3);
    if (!m_xip) send_byte(8'hEB);
    for (int i = 5; i >= 0; i--) cyc(addr[i*4 +: 4], d, o);
    cyc({junk, xb}, d, o);
    m_xip = !m_cfg[3] && !xb;
    for (int i = 1; i < DUMMY; i++) cyc(4'h0, d, o);
    chk(o == 4'h0, {tag, " lines idle in dummy"}, o, 0);
    for (int b = 0; b < nbytes; b++) begin
      cyc(4'h0, hi, ohi);
      cyc(4'h0, lo, olo);
      a = addr + 24'(b);
      chk({hi, lo} == memf(a), {tag, " data"}, {hi, lo}, memf(a));
      chk(ohi == 4'hF && olo == 4'hF, {tag, " R2 enables"}, {ohi, olo}, 8'hFF);
    end
    stop(mode3);
    chk(dq_oe == 4'h0, "R9 release after deselect", dq_oe, 0);
    chk(fetch_cnt == nbytes + 1 + (mode3 ? 0 : 1), "R12 fetch count",
        fetch_cnt, nbytes + 1 + (mode3 ? 0 : 1));
    chk(first_addr == addr, "R12 first fetch address", first_addr, addr);
  endtask

  task automatic cfg_write(input logic [7:0] v, input bit mode3);
    start(mode3);
    send_byte(8'h81);
    send_byte(v);
    stop(mode3);
    m_cfg = v;
  endtask

  task automatic bad_op(input logic [7:0] op);
    logic [3:0] d, o;
    int seen = 0;
    start(1'b0);
    send_byte(op);
    for (int i = 0; i < 16; i++) begin
      cyc(4'hF, d, o);
      if (o != 4'h0) seen++;
    end
    stop(1'b0);
    chk(seen == 0, "R10 lines stay undriven", seen, 0);
  endtask

  task automatic abort_addr();
    logic [3:0] d, o;
    start(1'b1);
    if (!m_xip) send_byte(8'hEB);
    for (int i = 0; i < 3; i++) cyc(4'h7, d, o);
    stop(1'b1);
  endtask

  initial begin
    wclk(5);
    chk(dq_oe == 4'h0, "R1 enables low in reset", dq_oe, 0);
    rst_ni = 1'b1;
    wclk(5);
    chk(dq_oe == 4'h0, "R1 enables low after reset", dq_oe, 0);
    chk(mem_en == 1'b0, "R1 no memory read", mem_en, 0);

    qread(0, 24'h123456, 0, 3'b000, 4, "R1 R2 R8 opcode read mode 0");
    qread(1, 24'hABCDEF, 0, 3'b000, 3, "R11 R8 opcode read mode 3");
    qread(0, 24'hFFFFFE, 1, 3'b000, 3, "R3 wrap");
    bad_op(8'h03);
    qread(1, 24'h000010, 0, 3'b000, 2, "R10 decode after bad opcode");

    cfg_write(8'hF7, 0);
    qread(0, 24'h00ABCD, 0, 3'b000, 2, "R4 read after config write");
    qread(1, 24'h777777, 0, 3'b111, 2, "R5 R7 address-first read");
    abort_addr();
    qread(0, 24'h345678, 1, 3'b000, 2, "R9 R5 restart after abort");
    qread(1, 24'h0F0F0F, 0, 3'b101, 2, "R6 opcode read after exit");
    qread(0, 24'h55AA55, 1, 3'b010, 1, "R5 R7 address-first then exit");
    qread(1, 24'h100000, 1, 3'b000, 1, "R6 opcode-first after exit");

    cfg_write(8'hFF, 1);
    qread(1, 24'h222222, 0, 3'b000, 1, "R4 R8 disabled ignores zero bit");
    qread(0, 24'h333333, 0, 3'b000, 2, "R8 still opcode-first");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule